// File: doc/BRIEF.md
# Audio Control Command Decoder

This block sits behind a serial bus receiver and turns each received control byte into settings for a two-channel audio path. The leading bits of a byte select its kind:

- volume attenuation,
- soft-mute and loudness,
- source selection,
- the left/right write mask.

Each kind updates its own latched registers. The registers hold their values until another byte of the same kind overwrites them.

A volume byte carries two fields. A 4-bit coarse field counts 8 dB steps, and a 3-bit fine field counts 1 dB steps. A coarse value with both upper bits set means mute. The byte is written only into the channels enabled by the write mask, which is loaded by an earlier byte. The block outputs per-channel attenuation in dB as one 7-bit number, a per-channel mute flag, the soft-mute mode, the loudness level, a one-hot source select and the current mask. All outputs come straight from registers.

Top module: `audio_cmd_decoder`

## Requirements
- R1: While rst is high and after its release, until a byte is accepted, the outputs are: both channels muted with attenuation 127, soft mute on in slow mode, loudness off (loud_db=00), no source (src_sel=000), and mask 2'b10 (left only).
- R2: A byte is accepted on a rising clk edge where byte_valid is high, and its effect is visible on the outputs right after that edge. Bit 7 = 0 means volume. Otherwise bits 7..5 decode as follows: 100 is mute/loudness, 101 is source select, 110 is write mask.
- R3: For a volume byte, the coarse field is bits 6..3 (values 0..11) and the fine field is bits 2..0. Each enabled channel gets attenuation = 8*coarse + fine, and its mute flag is cleared.
- R4: A volume byte whose bits 6..5 are 11 sets the mute flag of each enabled channel and forces its attenuation to 127, whatever the fine field holds.
- R5: A volume byte writes the left channel only if chan_mask[1] is 1, and the right channel only if chan_mask[0] is 1. A disabled channel keeps its value.
- R6: A write-mask byte loads its bits 1..0 into chan_mask. A volume byte accepted on the very next edge already uses the new mask.
- R7: Source select uses bits 1..0 of the byte. 00 gives src_sel=000 (no source). 01 gives 010 (input 2). 10 gives 100 (input 3). 11 gives 001 (input 1).
- R8: A mute/loudness byte with bit 4 = 0 is a soft-mute command. If bit 1 = 1, soft mute is turned off and the mode flag is kept. Otherwise soft mute is turned on, with fast mode when bit 0 = 1 and slow mode when bit 0 = 0.
- R9: A mute/loudness byte with bit 4 = 1 is a loudness command. If bit 0 = 1, loudness is off (00). Otherwise bit 1 chooses: 0 gives 10 dB (01) and 1 gives 20 dB (10). loud_db never reads 11.
- R10: A byte whose bits 7..5 are 111, and any cycle with byte_valid low, leave every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Byte present this cycle |
| byte_data | input | 8 | Received control byte |
| atten_l | output | 7 | Left attenuation in dB (127 when muted) |
| atten_r | output | 7 | Right attenuation in dB (127 when muted) |
| mute_l | output | 1 | Left volume mute |
| mute_r | output | 1 | Right volume mute |
| smute_on | output | 1 | Soft mute engaged |
| smute_fast | output | 1 | Soft mute mode: 1 fast, 0 slow |
| loud_db | output | 2 | Loudness: 00 off, 01 10 dB, 10 20 dB |
| src_sel | output | 3 | One-hot source: bit0 input 1, bit1 input 2, bit2 input 3 |
| chan_mask | output | 2 | Volume write mask: bit1 left, bit0 right |

## Verification
Two functions can meet on adjacent clock edges. A write-mask byte can be followed directly by a volume byte, so the new mask and its first use fall on successive edges. A mask of 11 also makes one volume byte update both channel registers in the same cycle. The bench provokes the first case by driving a mask byte and then a volume byte with no idle cycle between them. It judges the result by checking that only the newly enabled channel moved. It provokes the second case with mask 11 and expects identical attenuation on both channels after a single byte.

// File: rtl/audio_cmd_pkg.sv
package audio_cmd_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_VOL,
    CMD_MUTELOUD,
    CMD_INPUT,
    CMD_CHMASK
  } cmd_kind_e;

  localparam logic [1:0] LOUD_OFF = 2'b00;
  localparam logic [1:0] LOUD_10  = 2'b01;
  localparam logic [1:0] LOUD_20  = 2'b10;
endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import audio_cmd_pkg::*;
#(
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 3,
  localparam int ATTEN_W = COARSE_W + FINE_W,
  localparam int BYTE_W  = ATTEN_W + 1
) (
  input  logic              valid,
  input  logic [BYTE_W-1:0] data,
  output cmd_kind_e         kind,
  output logic              vol_mute,
  output logic [ATTEN_W-1:0] vol_atten
);
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;

  assign coarse = data[BYTE_W-2 -: COARSE_W];
  assign fine   = data[FINE_W-1:0];

  always_comb begin
    kind = CMD_NONE;
    if (valid) begin
      if (!data[BYTE_W-1]) begin
        kind = CMD_VOL;
      end else begin
        case (data[BYTE_W-2 -: 2])
          2'b00:   kind = CMD_MUTELOUD;
          2'b01:   kind = CMD_INPUT;
          2'b10:   kind = CMD_CHMASK;
          default: kind = CMD_NONE;
        endcase
      end
    end
  end

  assign vol_mute  = &coarse[COARSE_W-1 -: 2];
  assign vol_atten = (ATTEN_W'(coarse) << FINE_W) + ATTEN_W'(fine);
endmodule

// File: rtl/chan_volume.sv
module chan_volume #(
  parameter int ATTEN_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_mute,
  input  logic [ATTEN_W-1:0] wr_atten,
  output logic [ATTEN_W-1:0] atten_q,
  output logic               mute_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      atten_q <= '1;
      mute_q  <= 1'b1;
    end else if (wr_en) begin
      mute_q  <= wr_mute;
      atten_q <= wr_mute ? '1 : wr_atten;
    end
  end
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import audio_cmd_pkg::*;
#(
  parameter int          NUM_CH    = 2,
  parameter int          SRC_N     = 3,
  parameter logic [1:0]  MASK_INIT = 2'b10
) (
  input  logic              clk,
  input  logic              rst,
  input  cmd_kind_e         kind,
  input  logic              sel_loud,
  input  logic [1:0]        code,
  output logic [NUM_CH-1:0] mask_q,
  output logic              smute_on_q,
  output logic              smute_fast_q,
  output logic [1:0]        loud_q,
  output logic [SRC_N-1:0]  src_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q       <= MASK_INIT[NUM_CH-1:0];
      smute_on_q   <= 1'b1;
      smute_fast_q <= 1'b0;
      loud_q       <= LOUD_OFF;
      src_q        <= '0;
    end else begin
      case (kind)
        CMD_CHMASK: mask_q <= code[NUM_CH-1:0];
        CMD_INPUT: begin
          case (code)
            2'b00:   src_q <= '0;
            2'b01:   src_q <= SRC_N'(2);
            2'b10:   src_q <= SRC_N'(4);
            default: src_q <= SRC_N'(1);
          endcase
        end
        CMD_MUTELOUD: begin
          if (!sel_loud) begin
            if (code[1]) begin
              smute_on_q <= 1'b0;
            end else begin
              smute_on_q   <= 1'b1;
              smute_fast_q <= code[0];
            end
          end else begin
            if (code[0])      loud_q <= LOUD_OFF;
            else if (code[1]) loud_q <= LOUD_20;
            else              loud_q <= LOUD_10;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/audio_cmd_decoder.sv
module audio_cmd_decoder
  import audio_cmd_pkg::*;
#(
  parameter int COARSE_W = 4,
  parameter int FINE_W   = 3,
  localparam int ATTEN_W = COARSE_W + FINE_W,
  localparam int BYTE_W  = ATTEN_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_valid,
  input  logic [BYTE_W-1:0]  byte_data,
  output logic [ATTEN_W-1:0] atten_l,
  output logic [ATTEN_W-1:0] atten_r,
  output logic               mute_l,
  output logic               mute_r,
  output logic               smute_on,
  output logic               smute_fast,
  output logic [1:0]         loud_db,
  output logic [2:0]         src_sel,
  output logic [1:0]         chan_mask
);
  localparam int NUM_CH = 2;

  cmd_kind_e          kind;
  logic               vol_mute;
  logic [ATTEN_W-1:0] vol_atten;
  logic [ATTEN_W-1:0] ch_atten [NUM_CH];
  logic [NUM_CH-1:0]  ch_mute;

  cmd_classify #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_classify (
    .valid     (byte_valid),
    .data      (byte_data),
    .kind      (kind),
    .vol_mute  (vol_mute),
    .vol_atten (vol_atten)
  );

  ctrl_regs #(.NUM_CH(NUM_CH), .SRC_N(3), .MASK_INIT(2'b10)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .kind         (kind),
    .sel_loud     (byte_data[4]),
    .code         (byte_data[1:0]),
    .mask_q       (chan_mask),
    .smute_on_q   (smute_on),
    .smute_fast_q (smute_fast),
    .loud_q       (loud_db),
    .src_q        (src_sel)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    chan_volume #(.ATTEN_W(ATTEN_W)) u_vol (
      .clk      (clk),
      .rst      (rst),
      .wr_en    ((kind == CMD_VOL) && chan_mask[ch]),
      .wr_mute  (vol_mute),
      .wr_atten (vol_atten),
      .atten_q  (ch_atten[ch]),
      .mute_q   (ch_mute[ch])
    );
  end

  assign atten_l = ch_atten[1];
  assign atten_r = ch_atten[0];
  assign mute_l  = ch_mute[1];
  assign mute_r  = ch_mute[0];
endmodule

// File: rtl/audio_cmd_decoder_chk.sv
module audio_cmd_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic [7:0] byte_data,
  input logic [6:0] atten_l,
  input logic [6:0] atten_r,
  input logic       mute_l,
  input logic       mute_r,
  input logic       smute_on,
  input logic       smute_fast,
  input logic [1:0] loud_db,
  input logic [2:0] src_sel,
  input logic [1:0] chan_mask
);
  logic [25:0] all_out;
  assign all_out = {atten_l, atten_r, mute_l, mute_r, smute_on, smute_fast,
                    loud_db, src_sel, chan_mask};

  assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_data[7:5] == 3'b111) |=> $stable(all_out));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    !byte_valid |=> $stable(all_out));

  assert_mute_escape_R4: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_data[7] && byte_data[6:5] == 2'b11 && chan_mask[1])
      |=> (mute_l && atten_l == 7'd127));

  assert_atten_range_R3: assert property (@(posedge clk) disable iff (rst)
    (!mute_l |-> atten_l <= 7'd95) and (!mute_r |-> atten_r <= 7'd95));

  assert_left_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_data[7] && !chan_mask[1]) |=> $stable({atten_l, mute_l}));

  assert_right_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_data[7] && !chan_mask[0]) |=> $stable({atten_r, mute_r}));

  assert_src_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_sel));

  assert_loud_code_R9: assert property (@(posedge clk) disable iff (rst)
    loud_db != 2'b11);
endmodule

bind audio_cmd_decoder audio_cmd_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .atten_l    (atten_l),
  .atten_r    (atten_r),
  .mute_l     (mute_l),
  .mute_r     (mute_r),
  .smute_on   (smute_on),
  .smute_fast (smute_fast),
  .loud_db    (loud_db),
  .src_sel    (src_sel),
  .chan_mask  (chan_mask)
);

// File: tb/test_audio_cmd_decoder.sv
module test_audio_cmd_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic [6:0] atten_l, atten_r;
  logic       mute_l, mute_r, smute_on, smute_fast;
  logic [1:0] loud_db, chan_mask;
  logic [2:0] src_sel;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_cmd_decoder i_audio_cmd_decoder (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .atten_l(atten_l), .atten_r(atten_r), .mute_l(mute_l), .mute_r(mute_r),
    .smute_on(smute_on), .smute_fast(smute_fast), .loud_db(loud_db),
    .src_sel(src_sel), .chan_mask(chan_mask)
  );

  typedef struct {
    logic [6:0] al, ar;
    logic       ml, mr, son, sf;
    logic [1:0] ld, msk;
    logic [2:0] src;
    int         due;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  exp_t m;

  function automatic logic [25:0] pack_exp(exp_t e);
    return {e.al, e.ar, e.ml, e.mr, e.son, e.sf, e.ld, e.src, e.msk};
  endfunction

  function automatic logic [25:0] pack_dut();
    return {atten_l, atten_r, mute_l, mute_r, smute_on, smute_fast,
            loud_db, src_sel, chan_mask};
  endfunction

  task automatic model_reset();
    m.al = 7'd127; m.ar = 7'd127; m.ml = 1'b1; m.mr = 1'b1;
    m.son = 1'b1; m.sf = 1'b0; m.ld = 2'b00; m.src = 3'b000; m.msk = 2'b10;
  endtask

  task automatic model_apply(logic [7:0] b);
    logic [3:0] crs;
    logic [6:0] val;
    logic       mu;
    if (!b[7]) begin
      crs = b[6:3];
      mu  = (crs >= 4'd12);
      val = mu ? 7'd127 : 7'(crs) * 7'd8 + 7'(b[2:0]);
      if (m.msk[1]) begin m.al = val; m.ml = mu; end
      if (m.msk[0]) begin m.ar = val; m.mr = mu; end
    end else if (b[6:5] == 2'b00) begin
      if (!b[4]) begin
        if (b[1]) m.son = 1'b0;
        else begin m.son = 1'b1; m.sf = b[0]; end
      end else begin
        if (b[0]) m.ld = 2'b00;
        else m.ld = b[1] ? 2'b10 : 2'b01;
      end
    end else if (b[6:5] == 2'b01) begin
      case (b[1:0])
        2'b00: m.src = 3'b000;
        2'b01: m.src = 3'b010;
        2'b10: m.src = 3'b100;
        default: m.src = 3'b001;
      endcase
    end else if (b[6:5] == 2'b10) begin
      m.msk = b[1:0];
    end
  endtask

  // Driver: presents one byte for one cycle (valid may be low) and queues the expected state.
  task automatic drive(logic v, logic [7:0] b, string req);
    exp_t e;
    @(negedge clk);
    byte_valid = v;
    byte_data  = b;
    if (v) model_apply(b);
    e = m;
    e.due = cyc + 1;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  // Monitor: compares outputs 2 ns after the edge that should produce them.
  always begin
    @(posedge clk);
    cyc = cyc + 1;
    #2;
    while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (pack_dut() !== pack_exp(e)) begin
        errors++;
        $display("FAIL %s: got %h expected %h", e.req, pack_dut(), pack_exp(e));
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    checks++;
    if (pack_dut() !== {7'd127, 7'd127, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 3'b000, 2'b10}) begin
      errors++;
      $display("FAIL R1 in reset: got %h expected reset state", pack_dut());
    end
    rst = 1'b0;
    drive(1'b0, 8'h00, "R1 after release");
    drive(1'b1, 8'hC3, "R6 mask both");
    drive(1'b1, 8'h00, "R3 both 0 dB");
    drive(1'b1, 8'h5D, "R3 coarse 11 fine 5");
    drive(1'b1, 8'h2F, "R3 coarse 5 fine 7");
    drive(1'b1, 8'h01, "R3 fine only");
    drive(1'b1, 8'h63, "R4 mute escape 1100");
    drive(1'b1, 8'h7F, "R4 mute escape 1111");
    drive(1'b1, 8'hC2, "R6 mask left");
    drive(1'b1, 8'h10, "R5 left only");
    drive(1'b1, 8'hC1, "R6 mask right");
    drive(1'b1, 8'h08, "R5 right only");
    drive(1'b1, 8'hC0, "R6 mask none");
    drive(1'b1, 8'h00, "R5 no channel written");
    drive(1'b1, 8'hC2, "R6 back-to-back mask");
    drive(1'b1, 8'h18, "R6 volume uses new mask");
    idle();
    drive(1'b1, 8'hA0, "R7 no source");
    drive(1'b1, 8'hA1, "R7 input 2");
    drive(1'b1, 8'hA2, "R7 input 3");
    drive(1'b1, 8'hA3, "R7 input 1");
    drive(1'b1, 8'h81, "R8 fast on");
    drive(1'b1, 8'h82, "R8 off keeps mode");
    drive(1'b1, 8'h80, "R8 slow on");
    drive(1'b1, 8'h90, "R9 loud 10 dB");
    drive(1'b1, 8'h92, "R9 loud 20 dB");
    drive(1'b1, 8'h91, "R9 loud off");
    drive(1'b1, 8'h92, "R9 loud 20 dB again");
    drive(1'b1, 8'hE5, "R10 reserved prefix");
    drive(1'b1, 8'hFF, "R10 reserved all ones");
    drive(1'b0, 8'h00, "R10 valid low volume byte");
    drive(1'b0, 8'hA1, "R10 valid low source byte");
    drive(1'b1, 8'hA2, "R2 accepted next edge");
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule